// File: doc/BRIEF.md
# MOESI Snoop Coherence Controller

This block keeps the coherence state of every line of a small direct-mapped cache under a five-state protocol: Modified, Owned, Exclusive, Shared and Invalid. It sits between the cache's processor-side request port and a shared snooping bus. It does not handle data storage, tag compare, memory or bus arbitration. The processor side presents read, write and evict requests for a line index. The bus side presents transactions broadcast by the caching agents. The owning agent's own transactions come back on the snoop port as well.

The Owned state lets a dirty line be shared. A cache that holds a dirty line answers a peer's read by supplying the data itself, with no memory update first. The line moves to Owned and still owes memory a writeback when it is later evicted. When a processor request needs the bus, the controller raises one outstanding bus request. It holds that request until the arbiter grants it. In the grant cycle it samples the bus "shared" response and commits the final line state.

The snoop response (supply and shared) is combinational in the same cycle as the snooped command. The bus never grants this agent in the same cycle as it presents a snoop to the same line.

Top module: `moesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid: a snooped read of any index returns shared_o=0 and supply_o=0, and no bus request or completion is pending.
- R2: A processor read (cpu_op_i=0) of a valid line completes in the same cycle with no bus request. A read of an Invalid line raises bus_req_o with bus_cmd_o=1 (read) in the next cycle and completes in the grant cycle. The line fills to Exclusive if bus_shared_i is low at the grant and to Shared if it is high.
- R3: A processor write (cpu_op_i=1) to an Exclusive or Modified line completes in the same cycle with no bus traffic. A write to a Shared or Owned line requests bus_cmd_o=3 (invalidate). A write to an Invalid line requests bus_cmd_o=2 (read-for-ownership). Every write leaves the line Modified.
- R4: An evict (cpu_op_i=2) completes in the same cycle with no bus request and leaves the line Invalid. It raises wb_o for that one cycle only when the line was Modified or Owned.
- R5: A peer's snooped read (snoop_cmd_i=1) drives shared_o high for any valid line and supply_o high for a Modified or Owned line. It moves Modified to Owned and Exclusive to Shared, and leaves the other states unchanged.
- R6: A peer's snooped read-for-ownership (snoop_cmd_i=2) or invalidate (snoop_cmd_i=3) gives the same supply_o and shared_o response as R5 and moves the line to Invalid.
- R7: A snoop whose snoop_src_i equals the AGENT_ID parameter is this agent's own transaction. It produces no response and changes no state.
- R8: If a processor request in the idle state names the same index as a peer snoop in that cycle, the request does not complete in that cycle. The snoop is applied first, and the request is then served against the new state.
- R9: If a pending write's line is invalidated by a peer snoop while the write waits for its grant, bus_cmd_o changes from invalidate (3) to read-for-ownership (2).
- R10: Once raised, bus_req_o stays high with the same bus_cmd_o and bus_idx_o until bus_gnt_i. cpu_done_o stays low until then.
- R11: snoop_src_i identifies up to NUM_AGENTS (8 by default) agents, and any peer identity up to the largest gets the full snoop response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_req_i | input | 1 | Processor request valid, held until cpu_done_o |
| cpu_op_i | input | 2 | 0 read, 1 write, 2 evict |
| cpu_idx_i | input | IDX_W | Line index of the request |
| cpu_done_o | output | 1 | Request completes in this cycle |
| wb_o | output | 1 | Writeback of the evicted dirty line to memory |
| bus_req_o | output | 1 | Own bus transaction pending |
| bus_cmd_o | output | 2 | 1 read, 2 read-for-ownership, 3 invalidate |
| bus_idx_o | output | IDX_W | Line index of the own transaction |
| bus_gnt_i | input | 1 | Own transaction granted this cycle |
| bus_shared_i | input | 1 | Wired-OR shared response of peers, valid with grant |
| snoop_cmd_i | input | 2 | Snooped command, 0 none, encoding as bus_cmd_o |
| snoop_idx_i | input | IDX_W | Line index of the snooped command |
| snoop_src_i | input | AGENT_W | Issuing agent of the snooped command |
| supply_o | output | 1 | This cache drives the line data to the requester |
| shared_o | output | 1 | This cache holds a valid copy of the snooped line |

## Verification
The bench sweeps every start state against every processor and snoop operation. It then recovers the resulting state through the ports alone: a write probe, with a snoop injected while the upgrade waits, separates Invalid, Shared and Owned, and a replayed evict splits Exclusive from Modified. A controller that dropped dirtiness on a snooped read would lose the writeback at eviction. One that kept Exclusive after a peer read would make a later write silent instead of invalidating. The directed cases cover the same-index collision, where a wrong design would hit on a line that was just invalidated. They also cover the upgrade that loses its copy while waiting, where sending the stale invalidate would leave a Modified line with no data.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

  typedef enum logic [2:0] {
    LS_I = 3'd0,
    LS_S = 3'd1,
    LS_E = 3'd2,
    LS_O = 3'd3,
    LS_M = 3'd4
  } line_st_e;

  typedef enum logic [1:0] {
    CPU_RD = 2'd0,
    CPU_WR = 2'd1,
    CPU_EV = 2'd2,
    CPU_NOP = 2'd3
  } cpu_op_e;

  typedef enum logic [1:0] {
    BC_NONE = 2'd0,
    BC_READ = 2'd1,
    BC_RFO  = 2'd2,
    BC_INV  = 2'd3
  } bus_cmd_e;

  function automatic logic st_valid(line_st_e s);
    return s != LS_I;
  endfunction

  function automatic logic st_dirty(line_st_e s);
    return (s == LS_M) || (s == LS_O);
  endfunction

endpackage

// File: rtl/moesi_line_states.sv
module moesi_line_states
  import moesi_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cpu_we_i,
  input  logic [IDX_W-1:0]     cpu_idx_i,
  input  line_st_e             cpu_st_i,
  input  logic                 snp_we_i,
  input  logic [IDX_W-1:0]     snp_idx_i,
  input  line_st_e             snp_st_i,
  output line_st_e             st_o [NUM_LINES]
);

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    line_st_e st_q;
    // processor commit wins on a shared index (grant cycle only)
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q <= LS_I;
      end else if (cpu_we_i && (cpu_idx_i == IDX_W'(g))) begin
        st_q <= cpu_st_i;
      end else if (snp_we_i && (snp_idx_i == IDX_W'(g))) begin
        st_q <= snp_st_i;
      end
    end
    assign st_o[g] = st_q;
  end

endmodule

// File: rtl/moesi_snoop_unit.sv
module moesi_snoop_unit
  import moesi_pkg::*;
#(
  parameter int AGENT_W  = 3,
  parameter int AGENT_ID = 0
) (
  input  logic [1:0]         snoop_cmd_i,
  input  logic [AGENT_W-1:0] snoop_src_i,
  input  line_st_e           cur_st_i,
  output logic               active_o,
  output logic               supply_o,
  output logic               shared_o,
  output logic               we_o,
  output line_st_e           nxt_st_o
);

  always_comb begin
    active_o = (snoop_cmd_i != BC_NONE) && (snoop_src_i != AGENT_W'(AGENT_ID));
    supply_o = active_o && st_dirty(cur_st_i);
    shared_o = active_o && st_valid(cur_st_i);
    nxt_st_o = cur_st_i;
    if (active_o) begin
      case (bus_cmd_e'(snoop_cmd_i))
        BC_READ: begin
          if (cur_st_i == LS_M) nxt_st_o = LS_O;
          else if (cur_st_i == LS_E) nxt_st_o = LS_S;
        end
        BC_RFO, BC_INV: nxt_st_o = LS_I;
        default: nxt_st_o = cur_st_i;
      endcase
    end
    we_o = active_o && (nxt_st_o != cur_st_i);
  end

endmodule

// File: rtl/moesi_req_fsm.sv
module moesi_req_fsm
  import moesi_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpu_req_i,
  input  logic [1:0]       cpu_op_i,
  input  logic [IDX_W-1:0] cpu_idx_i,
  input  logic             conflict_i,
  input  line_st_e         cur_st_i,
  input  logic             bus_gnt_i,
  input  logic             bus_shared_i,
  output logic [IDX_W-1:0] look_idx_o,
  output logic             done_o,
  output logic             wb_o,
  output logic             bus_req_o,
  output logic [1:0]       bus_cmd_o,
  output logic [IDX_W-1:0] bus_idx_o,
  output logic             we_o,
  output logic [IDX_W-1:0] w_idx_o,
  output line_st_e         w_st_o
);

  typedef enum logic {FS_IDLE, FS_BUS} fsm_e;

  fsm_e             fsm_q, fsm_d;
  logic [1:0]       op_q;
  logic [IDX_W-1:0] idx_q;

  assign look_idx_o = (fsm_q == FS_BUS) ? idx_q : cpu_idx_i;
  assign bus_idx_o  = idx_q;

  always_comb begin
    fsm_d     = fsm_q;
    done_o    = 1'b0;
    wb_o      = 1'b0;
    bus_req_o = 1'b0;
    bus_cmd_o = BC_NONE;
    we_o      = 1'b0;
    w_idx_o   = cpu_idx_i;
    w_st_o    = LS_I;
    case (fsm_q)
      FS_IDLE: begin
        if (cpu_req_i && !conflict_i) begin
          case (cpu_op_e'(cpu_op_i))
            CPU_RD: begin
              if (st_valid(cur_st_i)) done_o = 1'b1;
              else fsm_d = FS_BUS;
            end
            CPU_WR: begin
              if ((cur_st_i == LS_E) || (cur_st_i == LS_M)) begin
                done_o = 1'b1;
                we_o   = 1'b1;
                w_st_o = LS_M;
              end else begin
                fsm_d = FS_BUS;
              end
            end
            CPU_EV: begin
              done_o = 1'b1;
              we_o   = st_valid(cur_st_i);
              w_st_o = LS_I;
              wb_o   = st_dirty(cur_st_i);
            end
            default: done_o = 1'b1;
          endcase
        end
      end
      FS_BUS: begin
        bus_req_o = 1'b1;
        w_idx_o   = idx_q;
        // a write whose copy was snooped away must fetch the line again
        if (op_q == CPU_RD)        bus_cmd_o = BC_READ;
        else if (cur_st_i == LS_I) bus_cmd_o = BC_RFO;
        else                       bus_cmd_o = BC_INV;
        if (bus_gnt_i) begin
          done_o = 1'b1;
          we_o   = 1'b1;
          fsm_d  = FS_IDLE;
          if (op_q == CPU_RD) w_st_o = bus_shared_i ? LS_S : LS_E;
          else                w_st_o = LS_M;
        end
      end
      default: fsm_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q <= FS_IDLE;
      op_q  <= CPU_RD;
      idx_q <= '0;
    end else begin
      fsm_q <= fsm_d;
      if ((fsm_q == FS_IDLE) && (fsm_d == FS_BUS)) begin
        op_q  <= cpu_op_i;
        idx_q <= cpu_idx_i;
      end
    end
  end

endmodule

// File: rtl/moesi_snoop_ctrl.sv
module moesi_snoop_ctrl
  import moesi_pkg::*;
#(
  parameter int  NUM_LINES  = 8,
  parameter int  NUM_AGENTS = 8,
  parameter int  AGENT_ID   = 0,
  localparam int IDX_W      = (NUM_LINES  > 1) ? $clog2(NUM_LINES)  : 1,
  localparam int AGENT_W    = (NUM_AGENTS > 1) ? $clog2(NUM_AGENTS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cpu_req_i,
  input  logic [1:0]         cpu_op_i,
  input  logic [IDX_W-1:0]   cpu_idx_i,
  output logic               cpu_done_o,
  output logic               wb_o,
  output logic               bus_req_o,
  output logic [1:0]         bus_cmd_o,
  output logic [IDX_W-1:0]   bus_idx_o,
  input  logic               bus_gnt_i,
  input  logic               bus_shared_i,
  input  logic [1:0]         snoop_cmd_i,
  input  logic [IDX_W-1:0]   snoop_idx_i,
  input  logic [AGENT_W-1:0] snoop_src_i,
  output logic               supply_o,
  output logic               shared_o
);

  line_st_e         line_st [NUM_LINES];
  logic [IDX_W-1:0] look_idx;
  line_st_e         req_st;
  line_st_e         snp_cur;
  logic             snp_act;
  logic             snp_we;
  line_st_e         snp_nxt;
  logic             cpu_we;
  logic [IDX_W-1:0] cpu_widx;
  line_st_e         cpu_wst;
  logic             conflict;

  assign req_st   = line_st[look_idx];
  assign snp_cur  = line_st[snoop_idx_i];
  assign conflict = snp_act && (snoop_idx_i == cpu_idx_i);

  moesi_line_states #(
    .NUM_LINES (NUM_LINES),
    .IDX_W     (IDX_W)
  ) u_states (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cpu_we_i  (cpu_we),
    .cpu_idx_i (cpu_widx),
    .cpu_st_i  (cpu_wst),
    .snp_we_i  (snp_we),
    .snp_idx_i (snoop_idx_i),
    .snp_st_i  (snp_nxt),
    .st_o      (line_st)
  );

  moesi_snoop_unit #(
    .AGENT_W  (AGENT_W),
    .AGENT_ID (AGENT_ID)
  ) u_snoop (
    .snoop_cmd_i (snoop_cmd_i),
    .snoop_src_i (snoop_src_i),
    .cur_st_i    (snp_cur),
    .active_o    (snp_act),
    .supply_o    (supply_o),
    .shared_o    (shared_o),
    .we_o        (snp_we),
    .nxt_st_o    (snp_nxt)
  );

  moesi_req_fsm #(
    .IDX_W (IDX_W)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cpu_req_i    (cpu_req_i),
    .cpu_op_i     (cpu_op_i),
    .cpu_idx_i    (cpu_idx_i),
    .conflict_i   (conflict),
    .cur_st_i     (req_st),
    .bus_gnt_i    (bus_gnt_i),
    .bus_shared_i (bus_shared_i),
    .look_idx_o   (look_idx),
    .done_o       (cpu_done_o),
    .wb_o         (wb_o),
    .bus_req_o    (bus_req_o),
    .bus_cmd_o    (bus_cmd_o),
    .bus_idx_o    (bus_idx_o),
    .we_o         (cpu_we),
    .w_idx_o      (cpu_widx),
    .w_st_o       (cpu_wst)
  );

endmodule

// File: rtl/moesi_snoop_ctrl_chk.sv
module moesi_snoop_ctrl_chk #(
  parameter int IDX_W    = 3,
  parameter int AGENT_W  = 3,
  parameter int AGENT_ID = 0
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cpu_req_i,
  input logic [1:0]         cpu_op_i,
  input logic [IDX_W-1:0]   cpu_idx_i,
  input logic               cpu_done_o,
  input logic               wb_o,
  input logic               bus_req_o,
  input logic [1:0]         bus_cmd_o,
  input logic [IDX_W-1:0]   bus_idx_o,
  input logic               bus_gnt_i,
  input logic               bus_shared_i,
  input logic [1:0]         snoop_cmd_i,
  input logic [IDX_W-1:0]   snoop_idx_i,
  input logic [AGENT_W-1:0] snoop_src_i,
  input logic               supply_o,
  input logic               shared_o
);

  p_wb_on_evict_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_o |-> (cpu_req_i && (cpu_op_i == 2'd2) && cpu_done_o && !bus_req_o));

  p_evict_no_bus_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && (cpu_op_i == 2'd2) && !bus_req_o) |=> !bus_req_o);

  p_supply_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    supply_o |-> shared_o);

  p_quiet_no_snoop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snoop_cmd_i == 2'd0) |-> (!supply_o && !shared_o));

  p_self_silent_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snoop_src_i == AGENT_W'(AGENT_ID)) |-> (!supply_o && !shared_o));

  p_conflict_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && !bus_req_o && (snoop_cmd_i != 2'd0) &&
     (snoop_src_i != AGENT_W'(AGENT_ID)) && (snoop_idx_i == cpu_idx_i)) |-> !cpu_done_o);

  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_gnt_i) |=> (bus_req_o && $stable(bus_idx_o)));

  p_cmd_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> (bus_cmd_o != 2'd0));

  p_wait_no_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_gnt_i) |-> !cpu_done_o);

  p_grant_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_gnt_i) |-> cpu_done_o);

  p_cmd_only_upgrade_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_gnt_i && (bus_cmd_o == 2'd2)) |=> (bus_cmd_o == 2'd2));

endmodule

bind moesi_snoop_ctrl moesi_snoop_ctrl_chk #(
  .IDX_W    (IDX_W),
  .AGENT_W  (AGENT_W),
  .AGENT_ID (AGENT_ID)
) u_chk (.*);

// File: tb/sim_moesi_snoop_ctrl.sv
module sim_moesi_snoop_ctrl;

  localparam int NL   = 8;
  localparam int NA   = 8;
  localparam int SELF = 2;
  localparam int PEER = 5;
  localparam int IW   = 3;
  localparam int AW   = 3;

  // bench-side state codes
  localparam int SI = 0, SS = 1, SE = 2, SO = 3, SM = 4, S_EM = 9;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cpu_req = 1'b0;
  logic [1:0]    cpu_op = '0;
  logic [IW-1:0] cpu_idx = '0;
  logic          cpu_done, wb, bus_req;
  logic [1:0]    bus_cmd;
  logic [IW-1:0] bus_idx;
  logic          bus_gnt = 1'b0, bus_shared = 1'b0;
  logic [1:0]    snoop_cmd = '0;
  logic [IW-1:0] snoop_idx = '0;
  logic [AW-1:0] snoop_src = '0;
  logic          supply, shared_out;

  int n_chk = 0;
  int n_err = 0;
  bit primary = 1'b1;

  always #2 clk = ~clk;

  moesi_snoop_ctrl #(.NUM_LINES(NL), .NUM_AGENTS(NA), .AGENT_ID(SELF)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .cpu_req_i(cpu_req), .cpu_op_i(cpu_op), .cpu_idx_i(cpu_idx),
    .cpu_done_o(cpu_done), .wb_o(wb),
    .bus_req_o(bus_req), .bus_cmd_o(bus_cmd), .bus_idx_o(bus_idx),
    .bus_gnt_i(bus_gnt), .bus_shared_i(bus_shared),
    .snoop_cmd_i(snoop_cmd), .snoop_idx_i(snoop_idx), .snoop_src_i(snoop_src),
    .supply_o(supply), .shared_o(shared_out)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; cpu_req = 1'b0; bus_gnt = 1'b0; snoop_cmd = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic cpu_do(input int op, input int idx, input int shr, input string tag,
                        output int imm, output int cmd, output int wbv);
    @(negedge clk);
    cpu_req = 1'b1; cpu_op = 2'(op); cpu_idx = IW'(idx); #1;
    imm = int'(cpu_done); wbv = int'(wb); cmd = 0;
    if (imm == 0) begin
      @(negedge clk);
      bus_gnt = 1'b1; bus_shared = shr[0]; #1;
      cmd = bus_req ? int'(bus_cmd) : 0;
      if (primary) check({tag, " done at grant"}, int'(cpu_done), 1);
    end
    @(negedge clk);
    cpu_req = 1'b0; bus_gnt = 1'b0; bus_shared = 1'b0;
  endtask

  task automatic snoop(input int c, input int idx, input int src, output int sup, output int shr);
    @(negedge clk);
    snoop_cmd = 2'(c); snoop_idx = IW'(idx); snoop_src = AW'(src); #1;
    sup = int'(supply); shr = int'(shared_out);
    @(negedge clk);
    snoop_cmd = '0;
  endtask

  task automatic setup(input int st, input int idx);
    int a, b, c;
    do_reset();
    case (st)
      SE: cpu_do(0, idx, 0, "setup", a, b, c);
      SS: cpu_do(0, idx, 1, "setup", a, b, c);
      SM: cpu_do(1, idx, 0, "setup", a, b, c);
      SO: begin cpu_do(1, idx, 0, "setup", a, b, c); snoop(1, idx, PEER, a, b); end
      default: ;
    endcase
  endtask

  // write probe: I via RFO, S/O via INV plus snoop while waiting, E/M silent
  task automatic probe_write(input int idx, output int cls);
    @(negedge clk);
    cpu_req = 1'b1; cpu_op = 2'd1; cpu_idx = IW'(idx); #1;
    if (cpu_done) begin
      cls = S_EM;
      @(negedge clk);
      cpu_req = 1'b0;
    end else begin
      @(negedge clk); #1;
      if (bus_cmd == 2'd2) begin
        cls = SI;
      end else begin
        snoop_cmd = 2'd1; snoop_idx = IW'(idx); snoop_src = AW'(PEER); #1;
        cls = supply ? SO : SS;
      end
      @(negedge clk);
      snoop_cmd = '0; bus_gnt = 1'b1;
      @(negedge clk);
      bus_gnt = 1'b0; cpu_req = 1'b0;
    end
  endtask

  function automatic int exp_next(input int s, input int op);
    case (op)
      0: return (s == SI) ? SE : s;
      1: return (s == SI) ? SS : s;
      2: return SM;
      3: return SI;
      4: return (s == SM) ? SO : ((s == SE) ? SS : s);
      5, 6: return SI;
      default: return s;
    endcase
  endfunction

  function automatic string op_tag(input int op);
    case (op)
      0, 1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5, 6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic apply_op(input int s, input int op, input int idx);
    int imm, cmd, wbv, sup, shr, ec;
    string t;
    t = op_tag(op);
    if (op <= 3) begin
      cpu_do((op <= 1) ? 0 : op - 1, idx, (op == 1) ? 1 : 0, t, imm, cmd, wbv);
      if (op <= 1)      ec = (s == SI) ? 1 : 0;
      else if (op == 2) ec = (s == SI) ? 2 : (((s == SS) || (s == SO)) ? 3 : 0);
      else              ec = 0;
      if (primary) begin
        check({t, " bus cmd"}, cmd, ec);
        check({t, " completes same cycle"}, imm, (ec == 0) ? 1 : 0);
        if (op == 3) check({t, " writeback"}, wbv, ((s == SM) || (s == SO)) ? 1 : 0);
      end
    end else begin
      snoop((op == 7) ? 2 : op - 3, idx, (op == 7) ? SELF : PEER, sup, shr);
      if (primary) begin
        check({t, " supply"}, sup, ((op != 7) && ((s == SM) || (s == SO))) ? 1 : 0);
        check({t, " shared"}, shr, ((op != 7) && (s != SI)) ? 1 : 0);
      end
    end
  endtask

  initial begin
    int a, b, c, sup, shr, cls, obs, idx;
    // watchdog
    fork
      begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog (all requirements): actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
      end
    join_none

    // R1: reset state
    do_reset();
    #1;
    check("R1 bus_req after reset", int'(bus_req), 0);
    check("R1 done after reset", int'(cpu_done), 0);
    for (int i = 0; i < NL; i++) begin
      snoop(1, i, PEER, sup, shr);
      check("R1 shared after reset", shr, 0);
      check("R1 supply after reset", sup, 0);
    end

    // sweep: every start state against every operation
    idx = 0;
    for (int s = 0; s < 5; s++) begin
      for (int op = 0; op < 8; op++) begin
        idx = (idx + 3) % NL;
        primary = 1'b1;
        setup(s, idx);
        apply_op(s, op, idx);
        probe_write(idx, cls);
        obs = cls;
        if (cls == S_EM) begin
          primary = 1'b0;
          setup(s, idx);
          apply_op(s, op, idx);
          cpu_do(2, idx, 0, "probe", a, b, c);
          obs = (c != 0) ? SM : SE;
          primary = 1'b1;
        end
        check({op_tag(op), " final state"}, obs, exp_next(s, op));
      end
    end

    // R8: same-index snoop and request in one cycle
    setup(SE, 2);
    @(negedge clk);
    cpu_req = 1'b1; cpu_op = 2'd0; cpu_idx = 3'd2;
    snoop_cmd = 2'd2; snoop_idx = 3'd2; snoop_src = AW'(PEER); #1;
    check("R8 no completion on collision", int'(cpu_done), 0);
    check("R8 snoop still answered", int'(shared_out), 1);
    @(negedge clk);
    snoop_cmd = '0; #1;
    check("R8 read now misses", int'(cpu_done), 0);
    @(negedge clk); #1;
    check("R8 bus read after snoop", int'(bus_cmd), 1);
    bus_gnt = 1'b1;
    @(negedge clk);
    bus_gnt = 1'b0; cpu_req = 1'b0;

    // R9: upgrade loses its copy while waiting
    setup(SS, 3);
    @(negedge clk);
    cpu_req = 1'b1; cpu_op = 2'd1; cpu_idx = 3'd3;
    @(negedge clk); #1;
    check("R9 initial invalidate", int'(bus_cmd), 3);
    snoop_cmd = 2'd2; snoop_idx = 3'd3; snoop_src = AW'(PEER); #1;
    check("R9 shared copy reported", int'(shared_out), 1);
    @(negedge clk);
    snoop_cmd = '0; #1;
    check("R9 command switched to rfo", int'(bus_cmd), 2);
    bus_gnt = 1'b1;
    @(negedge clk);
    bus_gnt = 1'b0; cpu_req = 1'b0;
    cpu_do(2, 3, 0, "R9", a, b, c);
    check("R9 line ends modified", c, 1);

    // R10: request held while grant withheld
    do_reset();
    @(negedge clk);
    cpu_req = 1'b1; cpu_op = 2'd1; cpu_idx = 3'd5;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      check("R10 request held", int'(bus_req), 1);
      check("R10 command stable", int'(bus_cmd), 2);
      check("R10 index stable", int'(bus_idx), 5);
      check("R10 not done while waiting", int'(cpu_done), 0);
    end
    bus_gnt = 1'b1; #1;
    check("R10 done at grant", int'(cpu_done), 1);
    @(negedge clk);
    bus_gnt = 1'b0; cpu_req = 1'b0; #1;
    check("R10 request dropped after grant", int'(bus_req), 0);

    // R11: highest agent identity served
    setup(SM, 7);
    snoop(1, 7, NA - 1, sup, shr);
    check("R11 supply to highest agent", sup, 1);
    check("R11 shared to highest agent", shr, 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule